// File: doc/BRIEF.md
# Event timer register interface

This block is the register front end of a multi-channel event timer. It takes single-cycle requests on a 64-bit bus where each request carries a byte count. It holds the global registers itself: a read-only capability word, a two-bit configuration register, a per-channel interrupt status vector and a 32-bit main counter. The main counter advances on a tick qualifier while the global enable is set. Requests that address a channel's own registers are decoded and forwarded to the channel array on a one-hot select. The channel's read word comes back on a shared return bus.

Both full 64-bit requests and 32-bit half-register requests are accepted. A 4-byte request with address bit 2 set works on the upper half of the addressed register. Requests with an unsupported size or a misaligned offset are dropped without any side effect, and a read of that kind returns zero. Read data is registered and appears one cycle after the read request.

The global register offsets are fixed: capability 0x000, configuration 0x010, status 0x020 and main counter 0x0F0. The channel registers start at 0x100 with a 0x20 stride per channel. Within a channel's window, word 0 (+0x00) is configuration, word 1 (+0x08) is comparator and word 2 (+0x10) is routing.

Top module: `ev_timer_regs`

## Requirements
- R1: Only a byte count of 4 or 8 is accepted. A write with any other count changes no state. A read with any other count returns 0.
- R2: A request whose address is not a multiple of its byte count is dropped. A write of that kind changes no state, and a read returns 0.
- R3: A 4-byte request with address bit 2 set targets bits 63:32. Its write data and write mask are moved up by 32 bits, and its read data is returned shifted down by 32 bits.
- R4: The capability word reads as follows. Bits 7:0 hold 0x01. Bits 12:8 hold NUM_TIMERS-1. Bit 13 is 0, meaning a 32-bit counter. Bit 15 is 1, meaning legacy routing is supported. Bits 31:16 hold 0x8086. Bits 63:32 hold the tick period in femtoseconds, 100000000 by default.
- R5: While configuration bit 0 (enable) is 1, the main counter increments by one in every cycle in which `tick_en` is high, and it wraps modulo 2^32. While enable is 0, the counter holds.
- R6: A write to the main counter merges the masked data into the zero-extended counter and keeps the low 32 bits, so an upper-half write leaves the value unchanged. If enable is 1, `arm_all` pulses for one cycle after that write.
- R7: When a configuration write changes enable from 0 to 1, `arm_all` pulses for one cycle. When it changes enable from 1 to 0, `stop_all` pulses for one cycle and every status bit is cleared.
- R8: Status bit i is set by `sts_set[i]` only while enable is 1. Writing a 1 to a status bit clears it, but a set request in the same cycle wins.
- R9: Configuration bit 0 (`glb_en`) and bit 1 (`leg_route`) are writable under the mask, and the other bits read as 0. After reset, the configuration, the status, the counter and the read data are all 0.
- R10: An accepted request at 0x100 + 0x20*i + 8*w, with i < NUM_TIMERS and w < 3, raises only `tmr_sel[i]` in the same cycle. It also drives `tmr_word` = w, the strobe `tmr_wr` or `tmr_rd`, and the steered data and mask. A read of that request returns `tmr_rdata`.
- R11: Any other offset, including a channel index of NUM_TIMERS or above and word 3, is unmapped. A read of it returns 0, and a write to it changes nothing.
- R12: Under any mix of requests, ticks and set requests, the state and outputs evolve as R1 to R11 define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the block |
| req_size | input | 4 | Byte count of the request |
| req_wdata | input | 64 | Write data, lower lanes for 4-byte requests |
| rsp_rdata | output | 64 | Registered read data |
| tick_en | input | 1 | Main counter tick qualifier |
| sts_set | input | NUM_TIMERS | Per-channel status set requests |
| glb_en | output | 1 | Global enable |
| leg_route | output | 1 | Legacy routing select |
| irq_status | output | NUM_TIMERS | Interrupt status vector |
| arm_all | output | 1 | One-cycle pulse that re-arms all channels |
| stop_all | output | 1 | One-cycle pulse that stops all channels |
| tmr_sel | output | NUM_TIMERS | One-hot channel select |
| tmr_wr | output | 1 | Channel write strobe |
| tmr_rd | output | 1 | Channel read strobe |
| tmr_word | output | 2 | Channel register word index |
| tmr_wdata | output | 64 | Steered channel write data |
| tmr_wmask | output | 64 | Channel write mask |
| tmr_rdata | input | 64 | Read word from the selected channel |

## Verification
The assertions check the following on every cycle:
- the counter increments by one per enabled tick and holds while disabled;
- `arm_all` pulses when enable rises;
- `stop_all` pulses and the status clears when enable falls;
- the channel select is at most one-hot;
- channel strobes occur only together with a request;
- reads with a bad size or a misaligned offset return zero.

Only the bench scenarios can show the exact content of the capability word, the upper-half steering of data and mask, the merge of counter writes, the priority of a set request over a clear in the same cycle, and the decoding of the channel windows and the unmapped holes. The bench does this by checking every cycle's outputs against an independent model under directed and random traffic.

// File: rtl/ev_timer_pkg.sv
package ev_timer_pkg;

    localparam int TIDX_W        = 5;
    localparam int OFF_CAP       = 'h000;
    localparam int OFF_CFG       = 'h010;
    localparam int OFF_STS       = 'h020;
    localparam int OFF_CNT       = 'h0F0;
    localparam int OFF_TMR       = 'h100;
    localparam int TMR_STRIDE_LG = 5;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CAP,
        TGT_CFG,
        TGT_STS,
        TGT_CNT,
        TGT_TMR
    } tgt_e;

    typedef struct packed {
        logic              acc;
        logic              rd;
        logic              wr;
        logic              hi;
        tgt_e              tgt;
        logic [TIDX_W-1:0] tidx;
        logic [1:0]        tword;
        logic [63:0]       wdata;
        logic [63:0]       wmask;
    } dec_t;

    // Synthesized capability word
    function automatic logic [63:0] cap_word(int unsigned ntim, int unsigned period_fs);
        logic [63:0] c;
        c        = '0;
        c[7:0]   = 8'h01;
        c[12:8]  = 5'(ntim - 1);
        c[13]    = 1'b0;
        c[15]    = 1'b1;
        c[31:16] = 16'h8086;
        c[63:32] = 32'(period_fs);
        return c;
    endfunction

endpackage

// File: rtl/ev_timer_decode.sv
module ev_timer_decode
    import ev_timer_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int NUM_TIMERS = 8
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_size,
    input  logic [63:0]       req_wdata,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(OFF_CAP);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STS);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFF_CNT);
    localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFF_TMR);
    localparam logic [ADDR_W-1:0] N_TMR = ADDR_W'(NUM_TIMERS);

    logic              size_ok;
    logic              align_ok;
    logic              acc;
    logic              hi;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] toff;
    logic [ADDR_W-1:0] slot;

    always_comb begin
        size_ok  = (req_size == 4'd4) || (req_size == 4'd8);
        align_ok = (req_size == 4'd8) ? (req_addr[2:0] == 3'b000)
                                      : (req_addr[1:0] == 2'b00);
        acc      = req_valid && size_ok && align_ok;
        hi       = (req_size == 4'd4) && req_addr[2];
        base     = {req_addr[ADDR_W-1:3], 3'b000};
        toff     = base - A_TMR;
        slot     = toff >> TMR_STRIDE_LG;

        dec       = '0;
        dec.acc   = acc;
        dec.rd    = acc && !req_write;
        dec.wr    = acc && req_write;
        dec.hi    = hi;
        dec.wdata = hi ? {req_wdata[31:0], 32'h0} : req_wdata;
        if (req_size == 4'd8) begin
            dec.wmask = '1;
        end else if (hi) begin
            dec.wmask = {{32{1'b1}}, 32'h0};
        end else begin
            dec.wmask = {32'h0, {32{1'b1}}};
        end

        dec.tgt = TGT_NONE;
        if (base == A_CAP) begin
            dec.tgt = TGT_CAP;
        end else if (base == A_CFG) begin
            dec.tgt = TGT_CFG;
        end else if (base == A_STS) begin
            dec.tgt = TGT_STS;
        end else if (base == A_CNT) begin
            dec.tgt = TGT_CNT;
        end else if (base >= A_TMR && slot < N_TMR && toff[4:3] != 2'd3) begin
            dec.tgt   = TGT_TMR;
            dec.tidx  = slot[TIDX_W-1:0];
            dec.tword = toff[4:3];
        end
    end

endmodule

// File: rtl/ev_timer_globals.sv
module ev_timer_globals #(
    parameter int NUM_TIMERS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_cfg,
    input  logic                  wr_sts,
    input  logic                  wr_cnt,
    input  logic [31:0]           wdata,
    input  logic [31:0]           wmask,
    input  logic                  tick_en,
    input  logic [NUM_TIMERS-1:0] sts_set,
    output logic [1:0]            cfg_o,
    output logic [NUM_TIMERS-1:0] sts_o,
    output logic [31:0]           cnt_o,
    output logic                  arm_o,
    output logic                  stop_o
);

    typedef struct packed {
        logic [1:0]            cfg;
        logic [NUM_TIMERS-1:0] sts;
        logic [31:0]           cnt;
        logic                  arm;
        logic                  stop;
    } glb_st_t;

    glb_st_t st_d, st_q;

    logic                  en;
    logic [1:0]            cfg_new;
    logic [NUM_TIMERS-1:0] clr;
    logic [NUM_TIMERS-1:0] setv;

    always_comb begin
        st_d      = st_q;
        st_d.arm  = 1'b0;
        st_d.stop = 1'b0;
        en        = st_q.cfg[0];
        cfg_new   = (st_q.cfg & ~wmask[1:0]) | (wdata[1:0] & wmask[1:0]);
        clr       = wr_sts ? (wdata[NUM_TIMERS-1:0] & wmask[NUM_TIMERS-1:0]) : '0;
        setv      = en ? sts_set : '0;

        // a set in the same cycle wins over a write-one-to-clear
        st_d.sts = (st_q.sts & ~clr) | setv;

        if (wr_cfg) begin
            st_d.cfg = cfg_new;
            if (cfg_new[0] && !en) begin
                st_d.arm = 1'b1;
            end
            if (!cfg_new[0] && en) begin
                st_d.stop = 1'b1;
                st_d.sts  = '0;
            end
        end

        if (wr_cnt) begin
            st_d.cnt = (st_q.cnt & ~wmask) | (wdata & wmask);
            if (en) begin
                st_d.arm = 1'b1;
            end
        end else if (en && tick_en) begin
            st_d.cnt = st_q.cnt + 32'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign sts_o  = st_q.sts;
    assign cnt_o  = st_q.cnt;
    assign arm_o  = st_q.arm;
    assign stop_o = st_q.stop;

endmodule

// File: rtl/ev_timer_regs.sv
module ev_timer_regs
    import ev_timer_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_TIMERS = 8,
    parameter int unsigned PERIOD_FS  = 100000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [3:0]            req_size,
    input  logic [63:0]           req_wdata,
    output logic [63:0]           rsp_rdata,
    input  logic                  tick_en,
    input  logic [NUM_TIMERS-1:0] sts_set,
    output logic                  glb_en,
    output logic                  leg_route,
    output logic [NUM_TIMERS-1:0] irq_status,
    output logic                  arm_all,
    output logic                  stop_all,
    output logic [NUM_TIMERS-1:0] tmr_sel,
    output logic                  tmr_wr,
    output logic                  tmr_rd,
    output logic [1:0]            tmr_word,
    output logic [63:0]           tmr_wdata,
    output logic [63:0]           tmr_wmask,
    input  logic [63:0]           tmr_rdata
);

    localparam logic [63:0] CAP_VAL = cap_word(NUM_TIMERS, PERIOD_FS);

    dec_t                  dec;
    logic [1:0]            glb_cfg;
    logic [NUM_TIMERS-1:0] glb_sts;
    logic [31:0]           glb_cnt;
    logic                  is_tmr;
    logic [63:0]           full;
    logic [63:0]           rd_d, rd_q;

    ev_timer_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_TIMERS(NUM_TIMERS)
    ) i_dec (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_size (req_size),
        .req_wdata(req_wdata),
        .dec      (dec)
    );

    ev_timer_globals #(
        .NUM_TIMERS(NUM_TIMERS)
    ) i_glb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_cfg (dec.wr && dec.tgt == TGT_CFG),
        .wr_sts (dec.wr && dec.tgt == TGT_STS),
        .wr_cnt (dec.wr && dec.tgt == TGT_CNT),
        .wdata  (dec.wdata[31:0]),
        .wmask  (dec.wmask[31:0]),
        .tick_en(tick_en),
        .sts_set(sts_set),
        .cfg_o  (glb_cfg),
        .sts_o  (glb_sts),
        .cnt_o  (glb_cnt),
        .arm_o  (arm_all),
        .stop_o (stop_all)
    );

    // Channel forwarding
    assign is_tmr = dec.acc && (dec.tgt == TGT_TMR);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_sel
        assign tmr_sel[i] = is_tmr && (dec.tidx == TIDX_W'(i));
    end

    assign tmr_wr    = is_tmr && dec.wr;
    assign tmr_rd    = is_tmr && dec.rd;
    assign tmr_word  = dec.tword;
    assign tmr_wdata = dec.wdata;
    assign tmr_wmask = dec.wmask;

    // Read path
    always_comb begin
        unique case (dec.tgt)
            TGT_CAP: full = CAP_VAL;
            TGT_CFG: full = {62'h0, glb_cfg};
            TGT_STS: full = 64'(glb_sts);
            TGT_CNT: full = {32'h0, glb_cnt};
            TGT_TMR: full = tmr_rdata;
            default: full = '0;
        endcase

        rd_d = rd_q;
        if (req_valid && !req_write) begin
            if (dec.rd) begin
                rd_d = dec.hi ? (full >> 32) : full;
            end else begin
                rd_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rsp_rdata  = rd_q;
    assign glb_en     = glb_cfg[0];
    assign leg_route  = glb_cfg[1];
    assign irq_status = glb_sts;

endmodule

// File: rtl/ev_timer_regs_chk.sv
module ev_timer_regs_chk #(
    parameter int ADDR_W     = 12,
    parameter int NUM_TIMERS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_write,
    input logic [ADDR_W-1:0]     req_addr,
    input logic [3:0]            req_size,
    input logic                  tick_en,
    input logic                  glb_en,
    input logic [31:0]           cnt,
    input logic [63:0]           rsp_rdata,
    input logic                  arm_all,
    input logic                  stop_all,
    input logic [NUM_TIMERS-1:0] irq_status,
    input logic [NUM_TIMERS-1:0] tmr_sel,
    input logic                  tmr_wr,
    input logic                  tmr_rd
);

    p_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && tick_en && !req_valid) |=> (cnt == $past(cnt) + 32'd1));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !req_valid) |=> $stable(cnt));

    p_bad_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size != 4'd4 && req_size != 4'd8)
        |=> (rsp_rdata == 64'h0));

    p_misalign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 4'd8 && req_addr[2:0] != 3'b000)
        |=> (rsp_rdata == 64'h0));

    p_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glb_en) |-> arm_all);

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glb_en) |-> (stop_all && irq_status == '0));

    p_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tmr_sel));

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_wr || tmr_rd) |-> (req_valid && $countones(tmr_sel) == 1));

endmodule

bind ev_timer_regs ev_timer_regs_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_TIMERS(NUM_TIMERS)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .tick_en   (tick_en),
    .glb_en    (glb_en),
    .cnt       (glb_cnt),
    .rsp_rdata (rsp_rdata),
    .arm_all   (arm_all),
    .stop_all  (stop_all),
    .irq_status(irq_status),
    .tmr_sel   (tmr_sel),
    .tmr_wr    (tmr_wr),
    .tmr_rd    (tmr_rd)
);

// File: tb/test_ev_timer_regs.sv
module test_ev_timer_regs;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 12;
    localparam int NT         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_size = '0;
    logic [63:0]   req_wdata = '0;
    logic [63:0]   rsp_rdata;
    logic          tick_en = 1'b0;
    logic [NT-1:0] sts_set = '0;
    logic          glb_en, leg_route, arm_all, stop_all, tmr_wr, tmr_rd;
    logic [NT-1:0] irq_status, tmr_sel;
    logic [1:0]    tmr_word;
    logic [63:0]   tmr_wdata, tmr_wmask, tmr_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [1:0]    m_cfg = '0;
    logic [NT-1:0] m_sts = '0;
    logic [31:0]   m_cnt = '0;
    logic [63:0]   m_rd  = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ev_timer_regs #(.ADDR_W(AW), .NUM_TIMERS(NT)) i_ev_timer_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .tick_en(tick_en), .sts_set(sts_set),
        .glb_en(glb_en), .leg_route(leg_route), .irq_status(irq_status),
        .arm_all(arm_all), .stop_all(stop_all), .tmr_sel(tmr_sel),
        .tmr_wr(tmr_wr), .tmr_rd(tmr_rd), .tmr_word(tmr_word),
        .tmr_wdata(tmr_wdata), .tmr_wmask(tmr_wmask), .tmr_rdata(tmr_rdata)
    );

    function automatic logic [63:0] chan_word(int idx, int w);
        return {16'hC0DE, 8'(idx), 6'd0, 2'(w), 16'hBEEF, 8'(idx), 6'd0, 2'(w)};
    endfunction

    function automatic logic [63:0] exp_cap();
        return (64'd100000000 << 32) | (64'h8086 << 16) | (64'd1 << 15)
             | (64'(NT - 1) << 8) | 64'd1;
    endfunction

    // Channel stub answering the shared read bus
    always_comb begin
        tmr_rdata = '0;
        for (int i = 0; i < NT; i++) begin
            if (tmr_sel[i]) tmr_rdata = chan_word(i, int'(tmr_word));
        end
    end

    task automatic chk(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit v, input bit w, input int a,
                        input int s, input logic [63:0] d, input bit tick,
                        input logic [NT-1:0] set);
        bit acc, hi, thit, en, arm, stop;
        int base, off, ti, tw;
        logic [63:0] m, dd, full, erd;
        logic [1:0] ncfg;
        logic [NT-1:0] nsts, clr;
        logic [31:0] ncnt;

        @(negedge clk);
        req_valid = v; req_write = w; req_addr = AW'(a); req_size = 4'(s);
        req_wdata = d; tick_en = tick; sts_set = set;

        acc  = v && (s == 4 || s == 8) && (a % s == 0);
        hi   = (s == 4) && a[2];
        base = a & ~7;
        m    = (s == 8) ? '1 : (hi ? 64'hFFFFFFFF_00000000 : 64'h00000000_FFFFFFFF);
        dd   = hi ? (d << 32) : d;
        thit = 0; ti = 0; tw = 0;
        if (base >= 'h100) begin
            off = base - 'h100; ti = off / 32; tw = (off % 32) / 8;
            thit = acc && ti < NT && tw != 3;
        end

        #1;
        chk(tag, "tmr_sel", 64'(tmr_sel), thit ? 64'(1 << ti) : 64'h0);
        chk(tag, "tmr_wr", 64'(tmr_wr), 64'(thit && w));
        chk(tag, "tmr_rd", 64'(tmr_rd), 64'(thit && !w));
        if (thit) begin
            chk(tag, "tmr_word", 64'(tmr_word), 64'(tw));
            chk(tag, "tmr_wmask", tmr_wmask, m);
            chk(tag, "tmr_wdata", tmr_wdata, dd);
        end

        if (base == 'h000) full = exp_cap();
        else if (base == 'h010) full = 64'(m_cfg);
        else if (base == 'h020) full = 64'(m_sts);
        else if (base == 'h0F0) full = 64'(m_cnt);
        else if (base >= 'h100 && ti < NT && tw != 3) full = chan_word(ti, tw);
        else full = '0;
        if (!v || w) erd = m_rd;
        else if (!acc) erd = '0;
        else erd = hi ? (full >> 32) : full;

        en = m_cfg[0]; arm = 0; stop = 0;
        clr  = (acc && w && base == 'h020) ? NT'(dd & m) : '0;
        nsts = (m_sts & ~clr) | (en ? set : '0);
        ncfg = m_cfg;
        if (acc && w && base == 'h010) begin
            ncfg = (m_cfg & ~m[1:0]) | (dd[1:0] & m[1:0]);
            if (ncfg[0] && !en) arm = 1;
            if (!ncfg[0] && en) begin stop = 1; nsts = '0; end
        end
        ncnt = m_cnt;
        if (acc && w && base == 'h0F0) begin
            ncnt = 32'(({32'h0, m_cnt} & ~m) | (dd & m));
            if (en) arm = 1;
        end else if (en && tick) begin
            ncnt = m_cnt + 32'd1;
        end

        @(posedge clk);
        #1;
        chk(tag, "rsp_rdata", rsp_rdata, erd);
        chk(tag, "arm_all", 64'(arm_all), 64'(arm));
        chk(tag, "stop_all", 64'(stop_all), 64'(stop));
        chk(tag, "glb_en", 64'(glb_en), 64'(ncfg[0]));
        chk(tag, "leg_route", 64'(leg_route), 64'(ncfg[1]));
        chk(tag, "irq_status", 64'(irq_status), 64'(nsts));
        m_cfg = ncfg; m_sts = nsts; m_cnt = ncnt; m_rd = erd;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int sizes[8] = '{1, 2, 4, 8, 8, 4, 4, 8};
        int addrs[8] = '{'h000, 'h004, 'h010, 'h014, 'h020, 'h024, 'h0F0, 'h0F4};
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9", "reset glb_en", 64'(glb_en), 64'h0);
        chk("R9", "reset status", 64'(irq_status), 64'h0);
        chk("R9", "reset rdata", rsp_rdata, 64'h0);
        chk("R9", "reset arm", 64'(arm_all), 64'h0);

        step("R4", 1, 0, 'h000, 8, 0, 0, '0);
        step("R3", 1, 0, 'h004, 4, 0, 0, '0);
        step("R4", 1, 0, 'h000, 4, 0, 0, '0);
        step("R9", 1, 0, 'h0F0, 8, 0, 0, '0);
        step("R1", 1, 0, 'h000, 2, 0, 0, '0);
        step("R1", 1, 1, 'h010, 1, 64'h1, 0, '0);
        step("R1", 1, 0, 'h010, 0, 0, 0, '0);
        step("R2", 1, 0, 'h014, 8, 0, 0, '0);
        step("R2", 1, 1, 'h014, 8, 64'h1, 0, '0);
        step("R2", 1, 1, 'h012, 4, 64'h1, 0, '0);
        step("R6", 1, 1, 'h0F0, 8, 64'hDEADBEEF_FFFFFFFE, 0, '0);
        step("R6", 1, 0, 'h0F0, 8, 0, 0, '0);
        step("R3", 1, 1, 'h0F4, 4, 64'h12345678, 0, '0);
        step("R3", 1, 0, 'h0F0, 4, 0, 0, '0);
        step("R7", 1, 1, 'h010, 4, 64'h1, 0, '0);
        step("R5", 0, 0, 0, 8, 0, 1, '0);
        step("R5", 0, 0, 0, 8, 0, 1, '0);
        step("R5", 0, 0, 0, 8, 0, 0, '0);
        step("R5", 1, 0, 'h0F0, 4, 0, 1, '0);
        step("R5", 1, 0, 'h0F0, 8, 0, 0, '0);
        step("R8", 0, 0, 0, 8, 0, 0, 8'h05);
        step("R8", 1, 1, 'h020, 8, 64'h1, 0, '0);
        step("R8", 1, 1, 'h020, 8, 64'h4, 0, 8'h04);
        step("R8", 1, 0, 'h020, 8, 0, 0, '0);
        step("R8", 1, 0, 'h024, 4, 0, 0, '0);
        step("R10", 1, 1, 'h148, 8, 64'hA1B2C3D4_E5F60718, 0, '0);
        step("R10", 1, 0, 'h1F4, 4, 0, 0, '0);
        step("R10", 1, 1, 'h104, 4, 64'h55, 0, '0);
        step("R10", 1, 0, 'h1F0, 8, 0, 0, '0);
        step("R11", 1, 0, 'h200, 8, 0, 0, '0);
        step("R11", 1, 0, 'h118, 8, 0, 0, '0);
        step("R11", 1, 1, 'h080, 8, '1, 0, '0);
        step("R11", 1, 0, 'h080, 8, 0, 0, '0);
        step("R6", 1, 1, 'h0F0, 4, 64'h10, 0, '0);
        step("R9", 1, 1, 'h010, 4, 64'h3, 0, '0);
        step("R9", 1, 0, 'h010, 8, 0, 0, '0);
        step("R8", 0, 0, 0, 8, 0, 0, 8'h80);
        step("R7", 1, 1, 'h010, 8, 64'h2, 0, '0);
        step("R8", 0, 0, 0, 8, 0, 0, 8'h03);
        step("R8", 1, 0, 'h020, 8, 0, 0, '0);
        step("R5", 0, 0, 0, 8, 0, 1, '0);
        step("R5", 1, 0, 'h0F0, 8, 0, 1, '0);

        for (int k = 0; k < 3000; k++) begin
            int a, s;
            s = sizes[$urandom % 8];
            case ($urandom % 4)
                0: a = addrs[$urandom % 8];
                1: a = 'h100 + ($urandom % 10) * 32 + ($urandom % 4) * 8 + ($urandom % 2) * 4;
                2: a = $urandom % 4096;
                default: a = 'h0F0;
            endcase
            step("R12", ($urandom % 4) != 0, ($urandom % 3) == 0, a, s,
                 {$urandom, $urandom}, ($urandom % 2) == 1, NT'($urandom % 256));
        end

        summary();
    end

endmodule